// File: doc/BRIEF.md
# Descriptor List Command Processor

This block walks a linked list of 32-bit command words held in memory and carries each one out in order. A start pulse hands it the list's first address. From then on it reads one word at a time over a simple request/response port. It decodes the word by its two lowest bits and acts on it.

Four command types are handled:

- **Redirect**: moves the fetch pointer to a new location.
- **Run or halt**: either kicks the attached processing engine and waits for it, or ends the list.
- **Queue**: kicks the engine and, once the engine reports completion, continues at a linked address.
- **Register burst**: writes a run of engine control registers. The data words for the burst follow the command directly in the list.

Burst writes leave through a register write port with per-byte enables. When the list ends, the block holds a completion flag and sits idle until the next start pulse.

Top module: `cmdlist_sequencer`

## Requirements
- R1: After reset `seq_idle` is 1 and `list_done`, `rd_req`, `reg_we` and `eng_start` are all 0.
- R2: A `start` pulse while idle makes the first fetch at `start_addr` with bits 1:0 cleared. Each word that does not redirect the list is followed by a fetch at the current address plus 4.
- R3: A word with bits 1:0 = 00 (redirect) makes the next fetch at the address formed from word bits 25:3, with address bits 2:0 forced to 0. All other word bits are ignored.
- R4: A word with bits 1:0 = 01 and bit 2 set ends the list. `list_done` and `seq_idle` go to 1 and no further fetch is made. The next `start` pulse clears `list_done` by the following cycle.
- R5: A word with bits 1:0 = 01 and bit 2 clear raises `eng_start` for exactly one cycle. No fetch is made until `eng_done` is seen. The next fetch is then at the command's address plus 4.
- R6: A word with bits 1:0 = 10 (queue) raises `eng_start` for one cycle and waits for `eng_done`. The next fetch is then at word bits 25:3 with address bits 2:0 forced to 0.
- R7: A word with bits 1:0 = 11 (register burst) is followed by N+1 data words, where N is word bits 31:24. Data word k writes `reg_wdata` = that word at `reg_idx` = (word bits 11:2 + k) mod 1024. Each write appears on `reg_we` in the cycle after the word's `rd_valid`. Fetching resumes at the word after the last data word.
- R8: During a burst, `reg_byte_en[i]` is the inverse of command bit 16+i. A set mask bit blocks byte lane i, and a clear bit enables it.
- R9: Data words of a burst are never decoded as commands, even when they look like a halt word.
- R10: Only one read is outstanding at a time. `rd_req` lasts one cycle, and no new request is issued until the matching `rd_valid` has been seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a list; accepted only while idle |
| start_addr | input | ADDR_W | Byte address of the first list word |
| rd_req | output | 1 | One-cycle read request |
| rd_addr | output | ADDR_W | Byte address of the requested word |
| rd_valid | input | 1 | Read data valid, one cycle, at least one cycle after the request |
| rd_data | input | 32 | Returned list word |
| reg_we | output | 1 | Register write strobe |
| reg_idx | output | IDX_W | Register index being written |
| reg_byte_en | output | 4 | Active-high byte lane enables |
| reg_wdata | output | 32 | Register write data |
| eng_start | output | 1 | One-cycle engine kick |
| eng_done | input | 1 | Engine completion pulse |
| seq_idle | output | 1 | No list being processed |
| list_done | output | 1 | Last list ended on a halt word; cleared by start |

## Verification
The bench sweeps every burst length up to four words against every byte mask. It uses start offsets that include a wrap past index 1023. A design that forgot to invert the mask, or that let the index saturate, would write the wrong lanes or registers. Every burst data word is shaped like a halt word, so a design that decoded data as commands would end the list early with too few writes.

Redirect and queue words carry junk in bits 2 and 31:26. A design that did not clear the low address bits or trimmed the field wrongly would fetch from the wrong place. Memory and engine latencies are varied, so a design that fetched while the engine ran, or issued a second read before the first returned, is caught by the fetch log.

// File: rtl/cmdseq_pkg.sv
// Package: shared field widths and the decoded command record.
// Assumes the command word layout is fixed at 32 bits with the type in bits 1:0.
package cmdseq_pkg;

    localparam int WORD_W  = 32;
    localparam int LINK_W  = 23;   // word bits 25:3
    localparam int CNT_W   = 8;    // word bits 31:24
    localparam int MASK_W  = 4;    // word bits 19:16
    localparam int OFS_W   = 10;   // word bits 11:2

    typedef enum logic [1:0] {
        OP_REDIRECT = 2'b00,
        OP_RUN      = 2'b01,
        OP_QUEUE    = 2'b10,
        OP_BURST    = 2'b11
    } op_e;

    typedef struct packed {
        op_e                op;
        logic               halt;
        logic [LINK_W-1:0]  link;
        logic [CNT_W-1:0]   count;
        logic [MASK_W-1:0]  mask;
        logic [OFS_W-1:0]   offset;
    } cmd_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_WAIT,
        ST_KICK,
        ST_ENGINE
    } state_e;

endpackage

// File: rtl/cmdseq_decode.sv
// Module: cmdseq_decode
// Splits a fetched list word into its command fields. Purely combinational.
// Assumes every two-bit type value is defined, so no error output exists.
module cmdseq_decode
    import cmdseq_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output cmd_t              cmd
);

    // Field extraction at the fixed bit positions of the command format.
    always_comb begin
        cmd.op     = op_e'(word[1:0]);
        cmd.halt   = word[2];
        cmd.link   = word[25:3];
        cmd.count  = word[31:24];
        cmd.mask   = word[19:16];
        cmd.offset = word[11:2];
    end

endmodule

// File: rtl/cmdseq_burst.sv
// Module: cmdseq_burst
// Holds the state of a register burst: remaining words, current index and
// the byte mask. Produces registered write outputs one cycle after a beat.
// Assumes a beat is only presented while active is high.
module cmdseq_burst #(
    parameter int IDX_W  = 10,
    parameter int CNT_W  = 8,
    parameter int BE_W   = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [CNT_W-1:0]  load_count,
    input  logic [IDX_W-1:0]  load_idx,
    input  logic [BE_W-1:0]   load_mask,
    input  logic              beat,
    input  logic [DATA_W-1:0] beat_data,
    output logic              active,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [BE_W-1:0]   wr_be,
    output logic [DATA_W-1:0] wr_data
);

    logic [CNT_W-1:0] remain_q;
    logic [IDX_W-1:0] idx_q;
    logic [BE_W-1:0]  mask_q;

    // Burst bookkeeping: capture on load, step index and count on each beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active   <= 1'b0;
            remain_q <= '0;
            idx_q    <= '0;
            mask_q   <= '0;
        end else if (load) begin
            active   <= 1'b1;
            remain_q <= load_count;
            idx_q    <= load_idx;
            mask_q   <= load_mask;
        end else if (beat) begin
            idx_q <= idx_q + IDX_W'(1);
            if (remain_q == '0) begin
                active <= 1'b0;
            end else begin
                remain_q <= remain_q - CNT_W'(1);
            end
        end
    end

    // Write port register: one strobe per beat, enables are the inverted mask.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_en   <= 1'b0;
            wr_idx  <= '0;
            wr_be   <= '0;
            wr_data <= '0;
        end else begin
            wr_en <= beat;
            if (beat) begin
                wr_idx  <= idx_q;
                wr_be   <= ~mask_q;
                wr_data <= beat_data;
            end
        end
    end

endmodule

// File: rtl/cmdseq_addr.sv
// Module: cmdseq_addr
// Forms the two candidate fetch addresses: the next sequential word and the
// 8-byte aligned link target taken from a command. Combinational.
// Assumes ADDR_W is at most 26 so the link field covers the address.
module cmdseq_addr #(
    parameter int ADDR_W = 26,
    parameter int LINK_W = 23
) (
    input  logic [ADDR_W-1:0] pc,
    input  logic [LINK_W-1:0] link,
    output logic [ADDR_W-1:0] seq_addr,
    output logic [ADDR_W-1:0] link_addr
);

    localparam int USE_W = ADDR_W - 3;

    logic [LINK_W-1:0] link_unused;

    // Sequential successor and aligned link target.
    always_comb begin
        seq_addr    = pc + ADDR_W'(4);
        link_addr   = {link[USE_W-1:0], 3'b000};
        link_unused = link;
    end

endmodule

// File: rtl/cmdlist_sequencer.sv
// Module: cmdlist_sequencer
// Top level: fetches command words one at a time, decodes them and drives
// the engine handshake and the register write port.
// Assumes one read outstanding at a time and rd_valid at least one cycle
// after rd_req; start is ignored unless idle.
module cmdlist_sequencer
    import cmdseq_pkg::*;
#(
    parameter int ADDR_W = 26,
    parameter int IDX_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_valid,
    input  logic [31:0]       rd_data,
    output logic              reg_we,
    output logic [IDX_W-1:0]  reg_idx,
    output logic [3:0]        reg_byte_en,
    output logic [31:0]       reg_wdata,
    output logic              eng_start,
    input  logic              eng_done,
    output logic              seq_idle,
    output logic              list_done
);

    state_e            state_q;
    logic [ADDR_W-1:0] pc_q;
    logic [ADDR_W-1:0] resume_q;
    logic              done_q;
    cmd_t              cmd;
    logic [ADDR_W-1:0] seq_addr;
    logic [ADDR_W-1:0] link_addr;
    logic              burst_active;
    logic              take_word;
    logic              burst_load;
    logic              burst_beat;

    cmdseq_decode u_decode (
        .word (rd_data),
        .cmd  (cmd)
    );

    cmdseq_addr #(
        .ADDR_W (ADDR_W),
        .LINK_W (LINK_W)
    ) u_addr (
        .pc        (pc_q),
        .link      (cmd.link),
        .seq_addr  (seq_addr),
        .link_addr (link_addr)
    );

    // Classify the arriving word as a burst beat or a command.
    always_comb begin
        take_word  = (state_q == ST_WAIT) && rd_valid;
        burst_beat = take_word && burst_active;
        burst_load = take_word && !burst_active && (cmd.op == OP_BURST);
    end

    cmdseq_burst #(
        .IDX_W  (IDX_W),
        .CNT_W  (CNT_W),
        .BE_W   (MASK_W),
        .DATA_W (WORD_W)
    ) u_burst (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (burst_load),
        .load_count (cmd.count),
        .load_idx   (IDX_W'(cmd.offset)),
        .load_mask  (cmd.mask),
        .beat       (burst_beat),
        .beat_data  (rd_data),
        .active     (burst_active),
        .wr_en      (reg_we),
        .wr_idx     (reg_idx),
        .wr_be      (reg_byte_en),
        .wr_data    (reg_wdata)
    );

    // Sequencer state, fetch pointer, resume pointer and completion flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            pc_q     <= '0;
            resume_q <= '0;
            done_q   <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        pc_q    <= {start_addr[ADDR_W-1:2], 2'b00};
                        done_q  <= 1'b0;
                        state_q <= ST_FETCH;
                    end
                end
                ST_FETCH: begin
                    state_q <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (rd_valid) begin
                        if (burst_active) begin
                            pc_q    <= seq_addr;
                            state_q <= ST_FETCH;
                        end else begin
                            case (cmd.op)
                                OP_REDIRECT: begin
                                    pc_q    <= link_addr;
                                    state_q <= ST_FETCH;
                                end
                                OP_RUN: begin
                                    if (cmd.halt) begin
                                        done_q  <= 1'b1;
                                        state_q <= ST_IDLE;
                                    end else begin
                                        resume_q <= seq_addr;
                                        state_q  <= ST_KICK;
                                    end
                                end
                                OP_QUEUE: begin
                                    resume_q <= link_addr;
                                    state_q  <= ST_KICK;
                                end
                                default: begin
                                    pc_q    <= seq_addr;
                                    state_q <= ST_FETCH;
                                end
                            endcase
                        end
                    end
                end
                ST_KICK: begin
                    state_q <= ST_ENGINE;
                end
                ST_ENGINE: begin
                    if (eng_done) begin
                        pc_q    <= resume_q;
                        state_q <= ST_FETCH;
                    end
                end
                default: begin
                    state_q <= ST_IDLE;
                end
            endcase
        end
    end

    // Port outputs derived from the state.
    always_comb begin
        rd_req    = (state_q == ST_FETCH);
        rd_addr   = pc_q;
        eng_start = (state_q == ST_KICK);
        seq_idle  = (state_q == ST_IDLE);
        list_done = done_q;
    end

endmodule

// File: rtl/cmdseq_checker.sv
// Module: cmdseq_checker
// Port-level properties of the sequencer, bound to every instance.
module cmdseq_checker #(
    parameter int ADDR_W = 26,
    parameter int IDX_W  = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_req,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              rd_valid,
    input logic              reg_we,
    input logic [IDX_W-1:0]  reg_idx,
    input logic              eng_start,
    input logic              seq_idle,
    input logic              list_done
);

    // R10: a request lasts one cycle.
    a_r10_req_single: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> !rd_req);

    // R2: fetch addresses are word aligned.
    a_r2_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> (rd_addr[1:0] == 2'b00));

    // R5: engine kick is a single-cycle pulse.
    a_r5_kick_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |=> !eng_start);

    // R5: no fetch while kicking the engine.
    a_r5_no_fetch_on_kick: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |-> !rd_req);

    // R7: a register write follows a returned word.
    a_r7_write_after_data: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> $past(rd_valid));

    // R7: consecutive writes step the index by one.
    a_r7_index_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && $past(reg_we, 3)) |-> (reg_idx == $past(reg_idx, 3) + IDX_W'(1)) || !$past(rd_valid, 1));

    // R4: completion implies idle.
    a_r4_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        list_done |-> seq_idle);

    // R1: idle means all outputs are quiet.
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        seq_idle |-> (!rd_req && !eng_start && !reg_we));

endmodule

bind cmdlist_sequencer cmdseq_checker #(
    .ADDR_W (ADDR_W),
    .IDX_W  (IDX_W)
) u_cmdseq_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_req    (rd_req),
    .rd_addr   (rd_addr),
    .rd_valid  (rd_valid),
    .reg_we    (reg_we),
    .reg_idx   (reg_idx),
    .eng_start (eng_start),
    .seq_idle  (seq_idle),
    .list_done (list_done)
);

// File: tb/cmdlist_sequencer_bench.sv
module cmdlist_sequencer_bench;

    localparam int ADDR_W = 26;
    localparam int IDX_W  = 10;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [ADDR_W-1:0] start_addr = '0;
    logic              rd_req;
    logic [ADDR_W-1:0] rd_addr;
    logic              rd_valid = 1'b0;
    logic [31:0]       rd_data = '0;
    logic              reg_we;
    logic [IDX_W-1:0]  reg_idx;
    logic [3:0]        reg_byte_en;
    logic [31:0]       reg_wdata;
    logic              eng_start;
    logic              eng_done = 1'b0;
    logic              seq_idle;
    logic              list_done;

    cmdlist_sequencer #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_cmdlist_sequencer (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
        .reg_we(reg_we), .reg_idx(reg_idx), .reg_byte_en(reg_byte_en),
        .reg_wdata(reg_wdata), .eng_start(eng_start), .eng_done(eng_done),
        .seq_idle(seq_idle), .list_done(list_done)
    );

    always #10 clk = ~clk;   // 50 MHz

    logic [31:0] mem [1024];
    int nvec = 0;
    int nfail = 0;
    int mem_lat = 1;
    int eng_lat = 1;
    int nf = 0, nw = 0, ne = 0, busy_fetch = 0, dbl_req = 0;
    logic [ADDR_W-1:0] fetch_log [64];
    logic [IDX_W-1:0]  widx_log [64];
    logic [3:0]        wbe_log [64];
    logic [31:0]       wdat_log [64];
    int m_cnt = 0, e_cnt = 0;
    logic [ADDR_W-1:0] m_addr = '0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Memory and engine models plus port monitor.
    initial begin
        forever begin
            @(negedge clk);
            rd_valid = 1'b0;
            eng_done = 1'b0;
            if (m_cnt != 0) begin
                m_cnt--;
                if (m_cnt == 0) begin
                    rd_valid = 1'b1;
                    rd_data  = mem[m_addr[11:2]];
                end
            end
            if (e_cnt != 0) begin
                e_cnt--;
                if (e_cnt == 0) eng_done = 1'b1;
            end
            if (rd_req) begin
                if (nf < 64) fetch_log[nf] = rd_addr;
                nf++;
                if (e_cnt != 0 || eng_done) busy_fetch++;
                if (m_cnt != 0) dbl_req++;
                m_cnt  = mem_lat;
                m_addr = rd_addr;
            end
            if (eng_start) begin
                ne++;
                e_cnt = eng_lat;
            end
            if (reg_we) begin
                if (nw < 64) begin
                    widx_log[nw] = reg_idx;
                    wbe_log[nw]  = reg_byte_en;
                    wdat_log[nw] = reg_wdata;
                end
                nw++;
            end
        end
    end

    // Launch a list and wait for it to end; also checks start clears done.
    task automatic run_list(input logic [ADDR_W-1:0] sa);
        int t;
        @(posedge clk);
        nf = 0; nw = 0; ne = 0; busy_fetch = 0; dbl_req = 0;
        @(negedge clk);
        start = 1'b1;
        start_addr = sa;
        @(negedge clk);
        start = 1'b0;
        chk("R4 done cleared by start", 32'(list_done), 32'd0);
        t = 0;
        while (!list_done && t < 3000) begin
            @(negedge clk);
            t++;
        end
        chk("R4 list ended with done and idle", {30'd0, list_done, seq_idle}, 32'd3);
        chk("R10 no overlapping reads", 32'(dbl_req), 32'd0);
    endtask

    function automatic logic [31:0] burst_word(input int cnt, input int msk, input int ofs);
        return {8'(cnt), 4'd0, 4'(msk), 4'd0, 10'(ofs), 2'b11};
    endfunction

    initial begin
        int ofs_set [3];
        int tgts [2];
        ofs_set[0] = 0; ofs_set[1] = 5; ofs_set[2] = 1022;
        tgts[0] = 32'h208; tgts[1] = 32'h3F8;
        for (int i = 0; i < 1024; i++) mem[i] = 32'h5;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 idle after reset", 32'(seq_idle), 32'd1);
        chk("R1 done low after reset", 32'(list_done), 32'd0);
        chk("R1 outputs quiet after reset", {29'd0, rd_req, reg_we, eng_start}, 32'd0);

        // R7 R8 R9: burst sweep over length, mask and start offset
        for (int c = 0; c < 4; c++) begin
            for (int m = 0; m < 16; m++) begin
                for (int oi = 0; oi < 3; oi++) begin
                    mem_lat = 1 + ((c + m + oi) % 3);
                    mem[32'h100 >> 2] = burst_word(c, m, ofs_set[oi]);
                    for (int k = 0; k <= c; k++)
                        mem[(32'h104 >> 2) + k] = 32'h5 | (k << 4) | (m << 12) | (oi << 20);
                    mem[(32'h104 >> 2) + c + 1] = 32'h5;
                    run_list(ADDR_W'(32'h100));
                    chk("R7 write count", 32'(nw), 32'(c + 1));
                    chk("R9 fetch count", 32'(nf), 32'(c + 3));
                    for (int k = 0; k <= c; k++) begin
                        chk("R7 register index", 32'(widx_log[k]), 32'((ofs_set[oi] + k) % 1024));
                        chk("R7 register data", wdat_log[k], 32'h5 | (k << 4) | (m << 12) | (oi << 20));
                        chk("R8 byte enables", 32'(wbe_log[k]), 32'((~m) & 4'hF));
                    end
                    for (int k = 0; k < c + 3; k++)
                        chk("R2 sequential fetch", 32'(fetch_log[k]), 32'h100 + 4 * k);
                    chk("R7 no engine kick", 32'(ne), 32'd0);
                end
            end
        end

        // R3 redirect with junk in bit 2 and bits 31:26
        for (int ti = 0; ti < 2; ti++) begin
            mem_lat = 1 + ti;
            mem[32'h40 >> 2] = {6'h3F, 23'(tgts[ti] >> 3), 1'b1, 2'b00};
            mem[tgts[ti] >> 2] = 32'h5;
            run_list(ADDR_W'(32'h40));
            chk("R3 fetch count", 32'(nf), 32'd2);
            chk("R3 redirect target", 32'(fetch_log[1]), 32'(tgts[ti]));
        end

        // R5 run without halt, and R6 queue, across latencies
        for (int ml = 1; ml <= 3; ml++) begin
            for (int el = 1; el <= 4; el++) begin
                mem_lat = ml;
                eng_lat = el;
                mem[32'h300 >> 2] = 32'h1;
                mem[32'h304 >> 2] = 32'h5;
                run_list(ADDR_W'(32'h300));
                chk("R5 one engine kick", 32'(ne), 32'd1);
                chk("R5 no fetch while engine busy", 32'(busy_fetch), 32'd0);
                chk("R5 resume after run", 32'(fetch_log[1]), 32'h304);

                mem[32'h400 >> 2] = {6'h2A, 23'(32'h508 >> 3), 1'b1, 2'b10};
                mem[32'h508 >> 2] = 32'h5;
                run_list(ADDR_W'(32'h400));
                chk("R6 one engine kick", 32'(ne), 32'd1);
                chk("R6 no fetch while engine busy", 32'(busy_fetch), 32'd0);
                chk("R6 queued target", 32'(fetch_log[1]), 32'h508);
                chk("R6 fetch count", 32'(nf), 32'd2);
            end
        end

        // R2 start address low bits cleared
        mem_lat = 1;
        mem[32'h100 >> 2] = 32'h5;
        run_list(ADDR_W'(32'h103));
        chk("R2 first fetch aligned", 32'(fetch_log[0]), 32'h100);

        // R4 halt leaves block idle with no further fetch
        repeat (10) @(negedge clk);
        chk("R4 no fetch after halt", 32'(nf), 32'd1);

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

endmodule